// File: doc/BRIEF.md
# Protected Paged Memory Access Controller

This block sits behind a byte-level serial command decoder and in front of a 1024-byte data array. The array is built from eight 128-byte blocks, and each block holds eight 16-byte pages. Every request carries a target space, a 10-bit address and, for writes, one data byte. The controller answers each request with an ack or a nack one cycle later, and a read also returns a data byte. Read rights and write rights are kept apart. They come from a protection page that is addressed separately from the data array. A second separate page holds an identification value.

Writes are collected in a one-page buffer. The first byte of a transaction fixes the page and the starting offset. Each following byte goes to the next offset and wraps inside the same page. A stop strobe commits the buffered bytes. During the commit the block raises busy for a parameterised number of cycles and refuses all new requests. A transaction that hits a write-protected area is refused as a whole. None of its bytes reach the array.

All storage (the data array, the protection page and the identification page) starts erased to 0xFF. Reset clears only the control state and leaves the stored bytes alone. COMMIT_CYCLES must be at least 16, because the commit writes one byte per cycle.

Top module: `pmac_top`

## Requirements
- R1: After power-up every data array byte, protection page byte and identification page byte reads as 0xFF. A read accepted at a clock edge presents its ack and its data after that same edge.
- R2: The target space is selected by `req_space`: 0 = data array (10-bit address), 1 = protection page, 2 = identification page. For spaces 1 and 2 only `req_addr[3:0]` selects the byte. The three spaces do not alias.
- R3: The protection page holds one control byte at each of four offsets. Offset 0 is block write rights and offset 1 is block read rights; in both, bit n is block n. Offset 2 is block 0 page write rights and offset 3 is block 0 page read rights; in both, bit n is page n. A bit value of 0 denies the access and a bit value of 1 allows it.
- R4: In block 0 an access is allowed only if neither the block bit nor the bit for the addressed page denies it. Blocks 1 to 7 use their block bit alone.
- R5: Read rights and write rights are independent. A region that is read-denied can still be written, and a region that is write-denied can still be read.
- R6: A read of a read-denied region is acknowledged and returns 0xFF.
- R7: The first write byte of a transaction sets the page and the offset. Each later byte uses the next offset and ignores its own address. The offset wraps from 15 to 0 inside the same page.
- R8: If the first byte of a write transaction targets a write-denied area, that byte and every later byte are nacked. The stop that follows commits nothing and does not raise busy.
- R9: A stop that closes an open, permitted, non-empty transaction raises busy on the next cycle. Busy stays high for exactly COMMIT_CYCLES cycles. The data is readable once busy falls. A stop with no open transaction has no effect.
- R10: A request that arrives while busy is high is nacked and has no effect. Any request to space 3 is also nacked.
- R11: Each request answers with exactly one of ack or nack, on the cycle after it. A request given in the same cycle as stop is dropped and gets neither.
- R12: A committed change to the protection page governs all requests after the commit, and rights can be granted back again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the control state |
| req_valid | input | 1 | Request strobe, one byte per cycle |
| req_write | input | 1 | 1 = write byte, 0 = read byte |
| req_space | input | 2 | Target space (data, protection, identification, reserved) |
| req_addr | input | 10 | Byte address |
| req_wdata | input | 8 | Write data byte |
| req_stop | input | 1 | Closes the transaction and commits the buffered page |
| rd_data | output | 8 | Read result for the last accepted read |
| ack | output | 1 | Request accepted |
| nack | output | 1 | Request refused |
| busy | output | 1 | Page commit in progress |

## Verification
The main function is tried with several write patterns. A two-byte write with a stray second address shows that only the first address counts. A three-byte write that starts at offset 14 shows whether wrapping stays inside the page or spills into the next one. Writes to all three spaces at the same low address show that they are kept apart. Protection patterns that deny only block writes, only block reads, only a block 0 page, or block 0 as a whole separate the block path from the page path and the read path from the write path. A follow-up read after each refused or blind write shows whether any byte leaked through. Requests given during busy and at the same time as stop check the refusal and drop rules.

// File: rtl/pmac_pkg.sv
package pmac_pkg;
    localparam int ADDR_W     = 10;
    localparam int BYTE_W     = 8;
    localparam int OFS_W      = 4;
    localparam int PG_W       = 3;
    localparam int BLK_W      = ADDR_W - OFS_W - PG_W;
    localparam int PAGE_BYTES = 1 << OFS_W;
    localparam int MEM_BYTES  = 1 << ADDR_W;
    localparam int AUX_W      = OFS_W + 1;
    localparam int AUX_BYTES  = 1 << AUX_W;

    // Offsets of the control bytes inside the protection page
    localparam int PROT_WR_BLK = 0;
    localparam int PROT_RD_BLK = 1;
    localparam int PROT_WR_PG  = 2;
    localparam int PROT_RD_PG  = 3;

    typedef enum logic [1:0] {
        SP_DATA = 2'b00,
        SP_PROT = 2'b01,
        SP_ID   = 2'b10,
        SP_RSVD = 2'b11
    } space_e;

    typedef struct packed {
        logic [(1<<PG_W)-1:0]  rd_pg;
        logic [(1<<PG_W)-1:0]  wr_pg;
        logic [(1<<BLK_W)-1:0] rd_blk;
        logic [(1<<BLK_W)-1:0] wr_blk;
    } prot_t;

    typedef struct packed {
        logic              we;
        space_e            space;
        logic [ADDR_W-1:0] addr;
        logic [BYTE_W-1:0] data;
    } commit_t;

    function automatic logic [AUX_W-1:0] aux_index(space_e sp, logic [OFS_W-1:0] ofs);
        return {sp == SP_ID, ofs};
    endfunction
endpackage

// File: rtl/pm_ram.sv
module pm_ram
    import pmac_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = BYTE_W
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cells [DEPTH];

    // Erased state: all ones
    initial begin
        for (int i = 0; i < DEPTH; i++) cells[i] = '1;
    end

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
        rdata <= cells[raddr];
    end
endmodule

// File: rtl/pm_guard.sv
module pm_guard
    import pmac_pkg::*;
(
    input  prot_t             prot,
    input  space_e            space,
    input  logic [ADDR_W-1:0] addr,
    output logic              rd_deny,
    output logic              wr_deny
);
    logic [BLK_W-1:0] blk;
    logic [PG_W-1:0]  pg;
    logic             in_data;
    logic             first_blk;

    always_comb begin
        blk       = addr[ADDR_W-1 -: BLK_W];
        pg        = addr[OFS_W +: PG_W];
        in_data   = (space == SP_DATA);
        first_blk = (blk == '0);
        rd_deny   = in_data & (~prot.rd_blk[blk] | (first_blk & ~prot.rd_pg[pg]));
        wr_deny   = in_data & (~prot.wr_blk[blk] | (first_blk & ~prot.wr_pg[pg]));
    end
endmodule

// File: rtl/pm_wbuf.sv
module pm_wbuf
    import pmac_pkg::*;
#(
    parameter int COMMIT_CYCLES = 40
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  space_e            go_space,
    input  logic [ADDR_W-1:0] go_addr,
    input  logic [BYTE_W-1:0] go_data,
    input  logic              go_deny,
    input  logic              stop,
    output logic              open_o,
    output logic              denied_o,
    output logic              busy_o,
    output commit_t           cm
);
    localparam int PH_W = $clog2(COMMIT_CYCLES) + 1;

    logic                     open_q, denied_q, busy_q;
    logic [PH_W-1:0]          phase;
    logic [PAGE_BYTES-1:0]    vmask;
    logic [OFS_W-1:0]         ptr;
    logic [ADDR_W-OFS_W-1:0]  base;
    space_e                   tx_space;
    logic [BYTE_W-1:0]        pbuf [PAGE_BYTES];
    logic [OFS_W-1:0]         ph_ofs;

    assign ph_ofs = phase[OFS_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q   <= 1'b0;
            denied_q <= 1'b0;
            busy_q   <= 1'b0;
            phase    <= '0;
            vmask    <= '0;
            ptr      <= '0;
            base     <= '0;
            tx_space <= SP_DATA;
        end else if (busy_q) begin
            if (int'(phase) == COMMIT_CYCLES - 1) begin
                busy_q <= 1'b0;
                phase  <= '0;
                vmask  <= '0;
            end else begin
                phase <= phase + 1'b1;
            end
        end else if (stop) begin
            open_q   <= 1'b0;
            denied_q <= 1'b0;
            if (open_q && !denied_q && (|vmask)) begin
                busy_q <= 1'b1;
                phase  <= '0;
            end else begin
                vmask <= '0;
            end
        end else if (go) begin
            if (!open_q) begin
                open_q   <= 1'b1;
                denied_q <= go_deny;
                tx_space <= go_space;
                base     <= go_addr[ADDR_W-1:OFS_W];
                ptr      <= go_addr[OFS_W-1:0] + 1'b1;
                if (!go_deny) begin
                    pbuf[go_addr[OFS_W-1:0]] <= go_data;
                    vmask <= PAGE_BYTES'(1) << go_addr[OFS_W-1:0];
                end else begin
                    vmask <= '0;
                end
            end else begin
                ptr <= ptr + 1'b1;
                if (!denied_q) begin
                    pbuf[ptr]  <= go_data;
                    vmask[ptr] <= 1'b1;
                end
            end
        end
    end

    always_comb begin
        cm.we    = busy_q && (int'(phase) < PAGE_BYTES) && vmask[ph_ofs];
        cm.space = tx_space;
        cm.addr  = {base, ph_ofs};
        cm.data  = pbuf[ph_ofs];
    end

    assign open_o   = open_q;
    assign denied_o = denied_q;
    assign busy_o   = busy_q;

    // R8
    denied_no_commit_chk: assert property (@(posedge clk) disable iff (rst)
        (stop && !busy_q && open_q && denied_q) |=> !busy_q);

    // R9
    busy_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_q) |-> $past(stop && open_q && !denied_q));
endmodule

// File: rtl/pmac_top.sv
module pmac_top
    import pmac_pkg::*;
#(
    parameter int COMMIT_CYCLES = 40
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [1:0]        req_space,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [BYTE_W-1:0] req_wdata,
    input  logic              req_stop,
    output logic [BYTE_W-1:0] rd_data,
    output logic              ack,
    output logic              nack,
    output logic              busy
);
    space_e            sp;
    prot_t             prot;
    logic              rd_deny, wr_deny;
    logic              tx_open, tx_denied, busy_w;
    commit_t           cm;
    logic [BYTE_W-1:0] ram_q;
    logic [BYTE_W-1:0] aux_mem [AUX_BYTES];
    logic [BYTE_W-1:0] aux_q;
    logic              ack_q, nack_q, rd_mask_q, rd_aux_q;
    logic              live, bad_sp, go, wr_refuse, rd_ok;

    initial begin
        for (int i = 0; i < AUX_BYTES; i++) aux_mem[i] = '1;
    end

    assign sp = space_e'(req_space);

    always_comb begin
        prot.wr_blk = aux_mem[PROT_WR_BLK];
        prot.rd_blk = aux_mem[PROT_RD_BLK];
        prot.wr_pg  = aux_mem[PROT_WR_PG];
        prot.rd_pg  = aux_mem[PROT_RD_PG];
    end

    pm_guard u_guard (
        .prot    (prot),
        .space   (sp),
        .addr    (req_addr),
        .rd_deny (rd_deny),
        .wr_deny (wr_deny)
    );

    always_comb begin
        live      = req_valid && !req_stop;
        bad_sp    = (sp == SP_RSVD);
        go        = live && req_write && !busy_w;
        wr_refuse = busy_w || (tx_open ? tx_denied : (bad_sp || wr_deny));
        rd_ok     = !busy_w && !bad_sp;
    end

    pm_wbuf #(.COMMIT_CYCLES(COMMIT_CYCLES)) u_wbuf (
        .clk      (clk),
        .rst      (rst),
        .go       (go),
        .go_space (sp),
        .go_addr  (req_addr),
        .go_data  (req_wdata),
        .go_deny  (bad_sp || wr_deny),
        .stop     (req_stop),
        .open_o   (tx_open),
        .denied_o (tx_denied),
        .busy_o   (busy_w),
        .cm       (cm)
    );

    pm_ram u_ram (
        .clk   (clk),
        .we    (cm.we && cm.space == SP_DATA),
        .waddr (cm.addr),
        .wdata (cm.data),
        .raddr (req_addr),
        .rdata (ram_q)
    );

    always_ff @(posedge clk) begin
        if (cm.we && cm.space != SP_DATA)
            aux_mem[aux_index(cm.space, cm.addr[OFS_W-1:0])] <= cm.data;
        aux_q <= aux_mem[aux_index(sp, req_addr[OFS_W-1:0])];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ack_q     <= 1'b0;
            nack_q    <= 1'b0;
            rd_mask_q <= 1'b0;
            rd_aux_q  <= 1'b0;
        end else begin
            if (req_write) begin
                ack_q  <= live && !wr_refuse;
                nack_q <= live && wr_refuse;
            end else begin
                ack_q  <= live && rd_ok;
                nack_q <= live && !rd_ok;
            end
            if (live && !req_write) begin
                rd_mask_q <= rd_deny;
                rd_aux_q  <= (sp != SP_DATA);
            end
        end
    end

    assign rd_data = rd_mask_q ? '1 : (rd_aux_q ? aux_q : ram_q);
    assign ack     = ack_q;
    assign nack    = nack_q;
    assign busy    = busy_w;

    // R11
    ack_nack_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(ack && nack));

    // R10
    busy_nack_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_stop && busy_w) |=> (nack && !ack));

    // R6
    rd_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_stop && !req_write && !busy_w && rd_deny) |=> (ack && rd_data == 8'hFF));
endmodule

// File: tb/pmac_top_test.sv
module pmac_top_test;
    localparam int CC = 20;
    localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_ST = 2'd2;
    localparam logic [1:0] D = 2'd0, P = 2'd1, I = 2'd2, X = 2'd3;
    // entry: {op, space, addr, data, expected ack/commit, expected data, requirement}
    localparam int NV = 59;
    localparam logic [34:0] VEC [NV] = '{
        {OP_RD, D, 10'h000, 8'h00, 1'b1, 8'hFF, 4'd1},  // R1
        {OP_RD, D, 10'h3FF, 8'h00, 1'b1, 8'hFF, 4'd1},  // R1
        {OP_RD, P, 10'h000, 8'h00, 1'b1, 8'hFF, 4'd1},  // R1
        {OP_RD, I, 10'h00F, 8'h00, 1'b1, 8'hFF, 4'd1},  // R1
        {OP_WR, D, 10'h012, 8'hA1, 1'b1, 8'h00, 4'd7},  // R7
        {OP_WR, D, 10'h3FF, 8'hA2, 1'b1, 8'h00, 4'd7},  // R7 address ignored
        {OP_ST, D, 10'h000, 8'h00, 1'b1, 8'h00, 4'd9},  // R9
        {OP_RD, D, 10'h012, 8'h00, 1'b1, 8'hA1, 4'd7},
        {OP_RD, D, 10'h013, 8'h00, 1'b1, 8'hA2, 4'd7},
        {OP_RD, D, 10'h011, 8'h00, 1'b1, 8'hFF, 4'd7},
        {OP_RD, D, 10'h3FF, 8'h00, 1'b1, 8'hFF, 4'd7},
        {OP_WR, D, 10'h02E, 8'hB1, 1'b1, 8'h00, 4'd7},  // R7 wrap
        {OP_WR, D, 10'h000, 8'hB2, 1'b1, 8'h00, 4'd7},
        {OP_WR, D, 10'h000, 8'hB3, 1'b1, 8'h00, 4'd7},
        {OP_ST, D, 10'h000, 8'h00, 1'b1, 8'h00, 4'd9},
        {OP_RD, D, 10'h02E, 8'h00, 1'b1, 8'hB1, 4'd7},
        {OP_RD, D, 10'h02F, 8'h00, 1'b1, 8'hB2, 4'd7},
        {OP_RD, D, 10'h020, 8'h00, 1'b1, 8'hB3, 4'd7},
        {OP_RD, D, 10'h030, 8'h00, 1'b1, 8'hFF, 4'd7},  // no spill
        {OP_WR, D, 10'h085, 8'hC3, 1'b1, 8'h00, 4'd9},
        {OP_ST, D, 10'h000, 8'h00, 1'b1, 8'h00, 4'd9},
        {OP_WR, D, 10'h105, 8'h77, 1'b1, 8'h00, 4'd9},
        {OP_ST, D, 10'h000, 8'h00, 1'b1, 8'h00, 4'd9},
        {OP_WR, D, 10'h031, 8'h44, 1'b1, 8'h00, 4'd9},
        {OP_ST, D, 10'h000, 8'h00, 1'b1, 8'h00, 4'd9},
        {OP_WR, I, 10'h005, 8'h5A, 1'b1, 8'h00, 4'd2},  // R2
        {OP_ST, D, 10'h000, 8'h00, 1'b1, 8'h00, 4'd2},
        {OP_RD, I, 10'h005, 8'h00, 1'b1, 8'h5A, 4'd2},
        {OP_RD, D, 10'h005, 8'h00, 1'b1, 8'hFF, 4'd2},
        {OP_RD, P, 10'h005, 8'h00, 1'b1, 8'hFF, 4'd2},
        {OP_WR, P, 10'h000, 8'hFD, 1'b1, 8'h00, 4'd3},  // R3 block1 write deny
        {OP_WR, P, 10'h000, 8'hFB, 1'b1, 8'h00, 4'd3},  // R3 block2 read deny
        {OP_ST, D, 10'h000, 8'h00, 1'b1, 8'h00, 4'd3},
        {OP_RD, P, 10'h001, 8'h00, 1'b1, 8'hFB, 4'd3},
        {OP_WR, D, 10'h085, 8'h00, 1'b0, 8'h00, 4'd8},  // R8
        {OP_WR, D, 10'h086, 8'h11, 1'b0, 8'h00, 4'd8},
        {OP_ST, D, 10'h000, 8'h00, 1'b0, 8'h00, 4'd8},
        {OP_RD, D, 10'h085, 8'h00, 1'b1, 8'hC3, 4'd5},  // R5 read still allowed
        {OP_RD, D, 10'h105, 8'h00, 1'b1, 8'hFF, 4'd6},  // R6
        {OP_WR, D, 10'h105, 8'h66, 1'b1, 8'h00, 4'd5},  // R5 write still allowed
        {OP_ST, D, 10'h000, 8'h00, 1'b1, 8'h00, 4'd5},
        {OP_RD, D, 10'h105, 8'h00, 1'b1, 8'hFF, 4'd6},
        {OP_WR, P, 10'h001, 8'hFF, 1'b1, 8'h00, 4'd12}, // R12 grant back
        {OP_ST, D, 10'h000, 8'h00, 1'b1, 8'h00, 4'd12},
        {OP_RD, D, 10'h105, 8'h00, 1'b1, 8'h66, 4'd12},
        {OP_WR, P, 10'h002, 8'hFE, 1'b1, 8'h00, 4'd3},  // page0 write deny
        {OP_WR, P, 10'h000, 8'hF7, 1'b1, 8'h00, 4'd3},  // page3 read deny
        {OP_ST, D, 10'h000, 8'h00, 1'b1, 8'h00, 4'd3},
        {OP_WR, D, 10'h003, 8'h12, 1'b0, 8'h00, 4'd4},  // R4 page bit
        {OP_ST, D, 10'h000, 8'h00, 1'b0, 8'h00, 4'd4},
        {OP_WR, D, 10'h013, 8'h99, 1'b1, 8'h00, 4'd4},
        {OP_ST, D, 10'h000, 8'h00, 1'b1, 8'h00, 4'd4},
        {OP_RD, D, 10'h013, 8'h00, 1'b1, 8'h99, 4'd4},
        {OP_RD, D, 10'h031, 8'h00, 1'b1, 8'hFF, 4'd4},
        {OP_RD, D, 10'h020, 8'h00, 1'b1, 8'hB3, 4'd4},
        {OP_WR, P, 10'h000, 8'hFE, 1'b1, 8'h00, 4'd4},  // block0 write deny, block1 open
        {OP_ST, D, 10'h000, 8'h00, 1'b1, 8'h00, 4'd4},
        {OP_WR, D, 10'h043, 8'h21, 1'b0, 8'h00, 4'd4},  // R4 block bit
        {OP_ST, D, 10'h000, 8'h00, 1'b0, 8'h00, 4'd4}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0, req_write = 1'b0, req_stop = 1'b0;
    logic [1:0] req_space = 2'd0;
    logic [9:0] req_addr = '0;
    logic [7:0] req_wdata = '0;
    logic [7:0] rd_data;
    logic       ack, nack, busy;
    int         n_run = 0, n_fail = 0;

    always #2.5 clk = ~clk;

    pmac_top #(.COMMIT_CYCLES(CC)) uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_space(req_space), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_stop(req_stop), .rd_data(rd_data), .ack(ack), .nack(nack), .busy(busy)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic do_req(input logic wr, input logic [1:0] sp, input logic [9:0] a,
                          input logic [7:0] d, input logic with_stop);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_space = sp; req_addr = a;
        req_wdata = d; req_stop = with_stop;
        @(negedge clk);
        req_valid = 1'b0; req_stop = 1'b0;
    endtask

    task automatic do_stop(output logic rose, output int len);
        @(negedge clk);
        req_stop = 1'b1;
        @(negedge clk);
        req_stop = 1'b0;
        rose = busy;
        len = 0;
        while (busy && len < 10 * CC) begin
            len++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic rose;
        int   len;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        check("R11 reset ack", ack, 0);
        check("R11 reset nack", nack, 0);
        check("R9 reset busy", busy, 0);

        for (int k = 0; k < NV; k++) begin
            logic [34:0] v;
            string tag;
            v = VEC[k];
            tag = $sformatf("R%0d vec%0d", v[3:0], k);
            case (v[34:33])
                OP_WR: begin
                    do_req(1'b1, v[32:31], v[30:21], v[20:13], 1'b0);
                    check({tag, " ack"}, ack, v[12]);
                    check({tag, " nack"}, nack, !v[12]);
                end
                OP_RD: begin
                    do_req(1'b0, v[32:31], v[30:21], 8'h00, 1'b0);
                    check({tag, " ack"}, ack, v[12]);
                    if (v[12]) check({tag, " data"}, rd_data, v[11:4]);
                end
                default: begin
                    do_stop(rose, len);
                    check({tag, " busy"}, rose, v[12]);
                    check({tag, " busy len"}, len, v[12] ? CC : 0);
                end
            endcase
        end

        // R10 reserved space
        do_req(1'b1, X, 10'h001, 8'h00, 1'b0);
        check("R10 rsvd wr nack", nack, 1);
        do_stop(rose, len);
        check("R10 rsvd no commit", rose, 0);
        do_req(1'b0, X, 10'h001, 8'h00, 1'b0);
        check("R10 rsvd rd nack", nack, 1);

        // R9 stop with nothing open
        do_stop(rose, len);
        check("R9 idle stop", rose, 0);

        // R11 request with stop same cycle dropped
        do_req(1'b0, D, 10'h013, 8'h00, 1'b1);
        check("R11 drop ack", ack, 0);
        check("R11 drop nack", nack, 0);

        // R10 requests during busy
        do_req(1'b1, D, 10'h3F0, 8'h5C, 1'b0);
        check("R10 pre ack", ack, 1);
        @(negedge clk);
        req_stop = 1'b1;
        @(negedge clk);
        req_stop = 1'b0;
        check("R9 busy up", busy, 1);
        req_valid = 1'b1; req_write = 1'b0; req_space = D; req_addr = 10'h3F0;
        @(negedge clk);
        check("R10 busy rd nack", nack, 1);
        check("R10 busy rd ack", ack, 0);
        req_write = 1'b1; req_addr = 10'h3F1; req_wdata = 8'hEE;
        @(negedge clk);
        req_valid = 1'b0;
        check("R10 busy wr nack", nack, 1);
        while (busy) @(negedge clk);
        do_req(1'b0, D, 10'h3F0, 8'h00, 1'b0);
        check("R9 committed", rd_data, 8'h5C);
        do_req(1'b0, D, 10'h3F1, 8'h00, 1'b0);
        check("R10 no effect", rd_data, 8'hFF);
        do_stop(rose, len);
        check("R10 no open tx", rose, 0);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule